// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block sits beside a USB on-the-go controller core and gathers its event pulses for a host processor. There are two pending words. The endpoint word holds transmit events for endpoint 0 and fifteen further transmit endpoints, plus receive events for fifteen receive endpoints. The core word holds nine USB-level events. Each event pulse latches a pending bit. Each pending word has a mask word. Software reaches every pending and mask word through separate set and clear aliases, so it can change single bits without a read-modify-write sequence.

The block drives one level interrupt line from the OR of all masked pending bits. Once the line has fired, it cannot fire again until software writes the end-of-interrupt register. This lets the interrupt handler clear whatever it has serviced without getting a second interrupt part way through. A control register holds a soft-reset bit that gives the core a one-cycle reset pulse and empties the wrapper's own state. A fixed revision register identifies the block.

Top module: `usb_irq_wrap`

## Requirements
- R1: After reset, both pending words and both mask words read zero, the interrupt line is low, and offset 0x00 reads the REVISION parameter.
- R2: Reads are combinational on bus_addr. Offset 0x08 reads bit0 = interrupt line and bit1 = waiting for end-of-interrupt. The end-of-interrupt offset 0x60 and every unmapped offset read zero.
- R3: In the endpoint word, bits 15:0 hold transmit events 15:0 and bits 31:17 hold receive events 14:0. Bit 16 always reads zero.
- R4: In the core word, core events 8:0 sit at bits 24:16, with the drive-VBUS change event at bit 24. All other bits always read zero.
- R5: A write to a pending set alias (endpoint 0x24, core 0x44) sets the pending bits given by the ones in the data. A write to a clear alias (0x28, 0x48) clears them. The base offset (0x20, 0x40) and both aliases read the pending word. Writes to the base offset have no effect.
- R6: Mask words sit at 0x2C (endpoint) and 0x4C (core). A write to the base offset loads the mask. The set aliases (0x30, 0x50) and clear aliases (0x34, 0x54) set and clear single mask bits. All three offsets read the mask.
- R7: The masked views (endpoint 0x38, core 0x58) read the pending word ANDed with its mask.
- R8: An event pulse that arrives in the same cycle as a clear-alias write to its bit leaves that bit pending.
- R9: While the block is armed and any masked bit is pending, the line rises at the next clock edge and the block disarms. While disarmed, the line falls when no masked bit is pending and does not rise again.
- R10: A write of any value to 0x60 drops the line and re-arms the block. The line rises again one edge later if a masked bit is still pending.
- R11: Writing 1 to bit 0 of 0x04 gives a one-cycle high on core_soft_rst_o, and the same bit reads at 0x04. At the end of that cycle, pending words, masks and the end-of-interrupt state return to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tx_evt_i | input | 16 | Transmit endpoint event pulses |
| rx_evt_i | input | 15 | Receive endpoint event pulses |
| core_evt_i | input | 9 | Core USB event pulses |
| irq_o | output | 1 | Level interrupt line |
| core_soft_rst_o | output | 1 | Soft-reset pulse to the controller core |

## Verification
The hardest state to reach from the ports is a disarmed block whose line has already fallen while new masked events keep arriving. Reaching it needs a fire, a software clear and then fresh events, all with no end-of-interrupt write in between. Random stimulus seldom produces that ordering, so a directed sequence builds it and checks that the line stays low until the end-of-interrupt write. The same sequence then checks that the line rises one edge after that write. A second directed case places a clear-alias write and a matching event pulse in the same cycle. Long random runs with sparse events and mixed alias writes then cover the rest against a bench model.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned TX_N     = 16;
  localparam int unsigned RX_N     = 15;
  localparam int unsigned CORE_N   = 9;
  localparam int unsigned CORE_LSB = 16;

  localparam logic [DW-1:0] EP_VALID   = 32'hFFFE_FFFF;
  localparam logic [DW-1:0] CORE_VALID = 32'h01FF_0000;

  localparam int unsigned OFF_REV    = 'h00;
  localparam int unsigned OFF_CTRL   = 'h04;
  localparam int unsigned OFF_STAT   = 'h08;
  localparam int unsigned OFF_EP     = 'h20;
  localparam int unsigned OFF_CORE   = 'h40;
  localparam int unsigned OFF_EOI    = 'h60;
  // Relative offsets inside one bank of seven words
  localparam int unsigned REL_SRC    = 'h00;
  localparam int unsigned REL_SSET   = 'h04;
  localparam int unsigned REL_SCLR   = 'h08;
  localparam int unsigned REL_MASK   = 'h0C;
  localparam int unsigned REL_MSET   = 'h10;
  localparam int unsigned REL_MCLR   = 'h14;
  localparam int unsigned REL_MASKED = 'h18;

  // Event pulses win over a software clear in the same cycle
  function automatic logic [DW-1:0] next_pending(
    input logic [DW-1:0] cur, input logic [DW-1:0] set_v,
    input logic [DW-1:0] clr_v, input logic [DW-1:0] evt,
    input logic [DW-1:0] valid);
    return ((cur & ~clr_v) | set_v | evt) & valid;
  endfunction

  function automatic logic [DW-1:0] next_mask(
    input logic [DW-1:0] cur, input logic load_en,
    input logic [DW-1:0] load_v, input logic [DW-1:0] set_v,
    input logic [DW-1:0] clr_v, input logic [DW-1:0] valid);
    return (load_en ? load_v : ((cur & ~clr_v) | set_v)) & valid;
  endfunction
endpackage

// File: rtl/usb_irq_bank.sv
module usb_irq_bank
  import usb_irq_pkg::*;
#(
  parameter logic [DW-1:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_sset,
  input  logic          wr_sclr,
  input  logic          wr_mload,
  input  logic          wr_mset,
  input  logic          wr_mclr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] src,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] masked
);
  logic [DW-1:0] src_q, mask_q;
  logic [DW-1:0] set_v, clr_v, mset_v, mclr_v;

  assign set_v  = wr_sset ? wdata : '0;
  assign clr_v  = wr_sclr ? wdata : '0;
  assign mset_v = wr_mset ? wdata : '0;
  assign mclr_v = wr_mclr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
    end else if (soft_rst) begin
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      src_q  <= next_pending(src_q, set_v, clr_v, evt, VALID);
      mask_q <= next_mask(mask_q, wr_mload, wdata, mset_v, mclr_v, VALID);
    end
  end

  assign src    = src_q;
  assign mask   = mask_q;
  assign masked = src_q & mask_q;
endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic pend,
  input  logic eoi_wr,
  output logic irq,
  output logic armed
);
  logic irq_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (soft_rst || eoi_wr) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (armed_q && pend) begin
      irq_q   <= 1'b1;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      irq_q   <= irq_q & pend;
    end
  end

  assign irq   = irq_q;
  assign armed = armed_q;
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usb_irq_pkg::*;
#(
  parameter int unsigned   ADDR_W   = 8,
  parameter logic [31:0]   REVISION = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       tx_evt_i,
  input  logic [14:0]       rx_evt_i,
  input  logic [8:0]        core_evt_i,
  output logic              irq_o,
  output logic              core_soft_rst_o
);
  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(OFF_REV);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(OFF_EOI);

  // Named internal events, visible to the bound checker
  logic [DW-1:0] ep_evt_w, core_evt_w;
  logic [DW-1:0] ep_src_w, ep_mask_w, ep_masked_w;
  logic [DW-1:0] core_src_w, core_mask_w, core_masked_w;
  logic          pend_w, eoi_wr_w, armed_w, irq_w;
  logic          ctrl_q;

  assign ep_evt_w   = {rx_evt_i, 1'b0, tx_evt_i};
  assign core_evt_w = {7'b0, core_evt_i, 16'b0};
  assign eoi_wr_w   = bus_wen && (bus_addr == A_EOI);

  logic [DW-1:0] bank_masked [2];
  logic [DW-1:0] bank_src    [2];
  logic [DW-1:0] bank_mask   [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int unsigned   BASE = (b == 0) ? OFF_EP : OFF_CORE;
    localparam logic [DW-1:0] VLD  = (b == 0) ? EP_VALID : CORE_VALID;
    logic hit_sset, hit_sclr, hit_mload, hit_mset, hit_mclr;
    assign hit_sset  = bus_wen && (bus_addr == ADDR_W'(BASE + REL_SSET));
    assign hit_sclr  = bus_wen && (bus_addr == ADDR_W'(BASE + REL_SCLR));
    assign hit_mload = bus_wen && (bus_addr == ADDR_W'(BASE + REL_MASK));
    assign hit_mset  = bus_wen && (bus_addr == ADDR_W'(BASE + REL_MSET));
    assign hit_mclr  = bus_wen && (bus_addr == ADDR_W'(BASE + REL_MCLR));

    usb_irq_bank #(.VALID(VLD)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (ctrl_q),
      .wr_sset  (hit_sset),
      .wr_sclr  (hit_sclr),
      .wr_mload (hit_mload),
      .wr_mset  (hit_mset),
      .wr_mclr  (hit_mclr),
      .wdata    (bus_wdata),
      .evt      ((b == 0) ? ep_evt_w : core_evt_w),
      .src      (bank_src[b]),
      .mask     (bank_mask[b]),
      .masked   (bank_masked[b])
    );
  end

  assign ep_src_w      = bank_src[0];
  assign ep_mask_w     = bank_mask[0];
  assign ep_masked_w   = bank_masked[0];
  assign core_src_w    = bank_src[1];
  assign core_mask_w   = bank_mask[1];
  assign core_masked_w = bank_masked[1];
  assign pend_w        = (|ep_masked_w) || (|core_masked_w);

  // Control: bit 0 is a single-cycle soft-reset pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 1'b0;
    else        ctrl_q <= !ctrl_q && bus_wen && (bus_addr == A_CTRL) && bus_wdata[0];
  end
  assign core_soft_rst_o = ctrl_q;

  usb_irq_gate gate_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (ctrl_q),
    .pend     (pend_w),
    .eoi_wr   (eoi_wr_w),
    .irq      (irq_w),
    .armed    (armed_w)
  );
  assign irq_o = irq_w;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_REV)  bus_rdata = REVISION;
    if (bus_addr == A_CTRL) bus_rdata = {31'b0, ctrl_q};
    if (bus_addr == A_STAT) bus_rdata = {30'b0, !armed_w, irq_w};
    for (int b = 0; b < 2; b++) begin
      int unsigned base;
      base = (b == 0) ? OFF_EP : OFF_CORE;
      if (bus_addr == ADDR_W'(base + REL_SRC) || bus_addr == ADDR_W'(base + REL_SSET) ||
          bus_addr == ADDR_W'(base + REL_SCLR))
        bus_rdata = bank_src[b];
      if (bus_addr == ADDR_W'(base + REL_MASK) || bus_addr == ADDR_W'(base + REL_MSET) ||
          bus_addr == ADDR_W'(base + REL_MCLR))
        bus_rdata = bank_mask[b];
      if (bus_addr == ADDR_W'(base + REL_MASKED))
        bus_rdata = bank_masked[b];
    end
  end
endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk
  import usb_irq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] ep_evt_w,
  input logic [DW-1:0] core_evt_w,
  input logic [DW-1:0] ep_src_w,
  input logic [DW-1:0] core_src_w,
  input logic [DW-1:0] ep_mask_w,
  input logic [DW-1:0] core_mask_w,
  input logic          pend_w,
  input logic          eoi_wr_w,
  input logic          armed_w,
  input logic          irq_o,
  input logic          core_soft_rst_o
);
  assert_bit16_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_src_w[16]);

  assert_core_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_src_w & ~CORE_VALID) == '0);

  assert_ep_evt_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_evt_w != '0 && !core_soft_rst_o) |=> ((ep_src_w & $past(ep_evt_w)) == $past(ep_evt_w)));

  assert_core_evt_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_evt_w != '0 && !core_soft_rst_o) |=> ((core_src_w & $past(core_evt_w)) == $past(core_evt_w)));

  assert_rise_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(pend_w) && $past(armed_w));

  assert_no_refire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_w && !irq_o && !eoi_wr_w && !core_soft_rst_o) |=> !irq_o);

  assert_eoi_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr_w |=> (!irq_o && armed_w));

  assert_softrst_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    core_soft_rst_o |=> !core_soft_rst_o);

  assert_softrst_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    core_soft_rst_o |=> (ep_src_w == '0 && core_src_w == '0 && ep_mask_w == '0 &&
                         core_mask_w == '0 && armed_w && !irq_o));
endmodule

bind usb_irq_wrap usb_irq_wrap_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .ep_evt_w        (ep_evt_w),
  .core_evt_w      (core_evt_w),
  .ep_src_w        (ep_src_w),
  .core_src_w      (core_src_w),
  .ep_mask_w       (ep_mask_w),
  .core_mask_w     (core_mask_w),
  .pend_w          (pend_w),
  .eoi_wr_w        (eoi_wr_w),
  .armed_w         (armed_w),
  .irq_o           (irq_o),
  .core_soft_rst_o (core_soft_rst_o)
);

// File: tb/usb_irq_wrap_tb.sv
`timescale 1ns/1ps
module usb_irq_wrap_tb_top;
  localparam logic [31:0] REV = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tx_evt_i = '0;
  logic [14:0] rx_evt_i = '0;
  logic [8:0]  core_evt_i = '0;
  logic        irq_o, core_soft_rst_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  usb_irq_wrap #(.ADDR_W(8), .REVISION(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt_i(tx_evt_i),
    .rx_evt_i(rx_evt_i), .core_evt_i(core_evt_i), .irq_o(irq_o),
    .core_soft_rst_o(core_soft_rst_o)
  );

  // Bench model state, built from the requirements
  logic [31:0] m_eps, m_epm, m_cos, m_com;
  logic        m_irq, m_armed, m_ctrl;

  function automatic logic [31:0] ep_word(input logic [15:0] tx, input logic [14:0] rx);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 16; i++) w[i] = tx[i];        // R3
    for (int i = 0; i < 15; i++) w[17 + i] = rx[i];
    return w;
  endfunction

  function automatic logic [31:0] core_word(input logic [8:0] ce);
    return {7'b0, ce, 16'b0};                           // R4
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return REV;
      8'h04: return {31'b0, m_ctrl};
      8'h08: return {30'b0, !m_armed, m_irq};
      8'h20, 8'h24, 8'h28: return m_eps;
      8'h2C, 8'h30, 8'h34: return m_epm;
      8'h38: return m_eps & m_epm;
      8'h40, 8'h44, 8'h48: return m_cos;
      8'h4C, 8'h50, 8'h54: return m_com;
      8'h58: return m_cos & m_com;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h04) return "R11";
    if (a == 8'h38 || a == 8'h58) return "R7";
    if (a >= 8'h20 && a <= 8'h28) return "R5";
    if (a >= 8'h40 && a <= 8'h48) return "R5";
    if (a >= 8'h2C && a <= 8'h34) return "R6";
    if (a >= 8'h4C && a <= 8'h54) return "R6";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic w, input logic [7:0] a, input logic [31:0] d,
                            input logic [31:0] epe, input logic [31:0] coe);
    logic [31:0] pe, pc, me, mc;
    logic pend;
    pend = ((m_eps & m_epm) != 0) || ((m_cos & m_com) != 0);
    if (m_ctrl) begin
      m_eps = 0; m_epm = 0; m_cos = 0; m_com = 0;
      m_irq = 0; m_armed = 1; m_ctrl = 0;
      return;
    end
    pe = m_eps; pc = m_cos; me = m_epm; mc = m_com;
    if (w) begin
      case (a)
        8'h24: pe = pe | d;
        8'h28: pe = pe & ~d;
        8'h2C: me = d;
        8'h30: me = me | d;
        8'h34: me = me & ~d;
        8'h44: pc = pc | d;
        8'h48: pc = pc & ~d;
        8'h4C: mc = d;
        8'h50: mc = mc | d;
        8'h54: mc = mc & ~d;
        default: ;
      endcase
    end
    m_eps = (pe | epe) & 32'hFFFE_FFFF;
    m_cos = (pc | coe) & 32'h01FF_0000;
    m_epm = me & 32'hFFFE_FFFF;
    m_com = mc & 32'h01FF_0000;
    m_ctrl = w && a == 8'h04 && d[0];
    if (w && a == 8'h60) begin m_irq = 0; m_armed = 1; end
    else if (m_armed && pend) begin m_irq = 1; m_armed = 0; end
    else if (!m_armed) m_irq = m_irq && pend;
  endtask

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [15:0] tx, input logic [14:0] rx, input logic [8:0] ce,
                     input string tag);
    @(negedge clk);
    bus_wen = w; bus_addr = a; bus_wdata = d;
    tx_evt_i = tx; rx_evt_i = rx; core_evt_i = ce;
    #1;
    chk((tag == "") ? tag_of(a) : tag, bus_rdata, exp_read(a));
    chk("R9 R10 irq", {31'b0, irq_o}, {31'b0, m_irq});
    chk("R11 pulse", {31'b0, core_soft_rst_o}, {31'b0, m_ctrl});
    @(posedge clk);
    model_step(w, a, d, ep_word(tx, rx), core_word(ce));
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1'b0, a, 32'h0, '0, '0, '0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, '0, '0, '0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    m_eps = 0; m_epm = 0; m_cos = 0; m_com = 0;
    m_irq = 0; m_armed = 1; m_ctrl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, "R1 revision");
    rd(8'h20, "R1 ep pending");
    rd(8'h2C, "R1 ep mask");
    rd(8'h40, "R1 core pending");
    rd(8'h4C, "R1 core mask");
    rd(8'h08, "R1 status");
    rd(8'h64, "R2 unmapped");

    // R3 layout via set alias and via pulses
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h20, "R3 set-all");
    wr(8'h28, 32'hFFFF_FFFF);
    cyc(1'b0, 8'h20, 0, 16'h8001, 15'h4001, 9'h0, "R3");
    rd(8'h20, "R3 tx/rx positions");
    // R5 write to base ignored
    wr(8'h20, 32'h0);
    rd(8'h24, "R5 base write ignored");
    // R4 drive-VBUS at bit 24
    cyc(1'b0, 8'h40, 0, 16'h0, 15'h0, 9'h100, "R4");
    rd(8'h48, "R4 drive-vbus bit");
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, "R4 field");
    // R8 event beats clear
    cyc(1'b1, 8'h28, 32'hFFFF_FFFF, 16'h0008, 15'h0, 9'h0, "R8");
    rd(8'h20, "R8 event kept");
    cyc(1'b1, 8'h48, 32'hFFFF_FFFF, 16'h0, 15'h0, 9'h001, "R8");
    rd(8'h40, "R8 core event kept");
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF);

    // R9 and R10: fire, clear, new events while disarmed, EOI
    wr(8'h30, 32'h0000_0001);
    cyc(1'b0, 8'h08, 0, 16'h0001, 15'h0, 9'h0, "R9");
    rd(8'h08, "R9 armed pending");
    rd(8'h08, "R9 fired");
    wr(8'h28, 32'h0000_0001);
    rd(8'h08, "R9 dropped");
    cyc(1'b0, 8'h38, 0, 16'h0001, 15'h0, 9'h0, "R9");
    rd(8'h38, "R7 pending while disarmed");
    rd(8'h08, "R9 no refire");
    rd(8'h08, "R9 no refire");
    wr(8'h60, 32'h1234_5678);
    rd(8'h08, "R10 after eoi");
    rd(8'h08, "R10 refired");
    wr(8'h60, 32'h0);

    // R11 soft reset
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h44, 32'h0100_0000);
    wr(8'h04, 32'h1);
    rd(8'h04, "R11 ctrl bit");
    rd(8'h4C, "R11 mask cleared");
    rd(8'h20, "R11 pending cleared");

    // Random phase
    seed = 32'd2024;
    void'($urandom(seed));
    for (int n = 0; n < 4000; n++) begin
      logic w;
      logic [7:0] a;
      logic [31:0] d;
      logic [15:0] tx;
      logic [14:0] rx;
      logic [8:0] ce;
      w = ($urandom % 10) < 4;
      a = 8'(($urandom % 26) * 4);
      d = $urandom;
      if (a == 8'h04 && ($urandom % 8) != 0) d[0] = 1'b0;
      tx = (($urandom % 6) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      rx = (($urandom % 8) == 0) ? 15'(1 << ($urandom % 15)) : 15'h0;
      ce = (($urandom % 8) == 0) ? 9'(1 << ($urandom % 9)) : 9'h0;
      cyc(w, a, d, tx, rx, ce, "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule